// File: doc/BRIEF.md
# Big-Endian Word Store with Sub-Word Access

This block models a battery-style scratch memory that is organised as 32-bit words and mapped into a physical address window. A system bus reaches it with byte, halfword or word accesses. The block subtracts the window base from the address and uses the resulting offset divided by four as the word index.

Narrow data sits in big-endian lane order inside each word. A narrow write merges into the stored word, so every lane outside the access keeps its value. Narrow reads come back right-justified and zero-extended.

A second port serves a maintenance agent. It takes only aligned whole-word accesses, addressed by byte offset from the start of the memory. It reports a misaligned address or one past the end with one-cycle error pulses, and it never touches the memory on a rejected access.

Top module: `nvram_lane_store`

## Requirements
- R1: Synchronous active-low reset clears every stored word and both read-data outputs to zero.
- R2: The bus word index is (bus_addr - BASE_ADDR) >> 2. A word access (size code 2'b10) writes or returns all 32 bits. Read data appears on bus_rdata one clock after the request and holds until the next bus read.
- R3: A byte read (size code 2'b00) returns the lane selected by offset bits 1:0, right-justified and zero-extended. Offset 0 selects bits 31:24, offset 1 bits 23:16, offset 2 bits 15:8 and offset 3 bits 7:0.
- R4: A byte write stores bus_wdata[7:0] into the selected lane only and leaves the other three lanes unchanged.
- R5: A halfword access (size code 2'b01) uses bits 15:0 when offset bit 1 is set and bits 31:16 when it is clear. Offset bit 0 is ignored. A halfword write replaces only that half with bus_wdata[15:0]. A halfword read is zero-extended.
- R6: Size code 2'b11 writes nothing and reads back zero.
- R7: A bus access whose offset is DEPTH*4 or more, including addresses below the base, writes nothing and reads back zero.
- R8: A maintenance access with dbg_addr[1:0] not zero raises dbg_err_align for one cycle, one clock later. It writes nothing and returns zero on dbg_rdata.
- R9: An aligned maintenance access with dbg_addr at DEPTH*4 or more raises dbg_err_range for one cycle, one clock later. It writes nothing and returns zero. The two error flags are never both high.
- R10: An accepted maintenance write stores the full word at index dbg_addr >> 2, and the bus sees that word. An accepted maintenance read returns the full word one clock later.
- R11: When the bus and the maintenance port write the same word in one cycle, the bus result is stored. That result is merged against the word as it stood before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Bus access strobe |
| bus_we | input | 1 | Bus write (1) or read (0) |
| bus_size | input | 2 | 00 byte, 01 halfword, 10 word |
| bus_addr | input | 32 | Physical byte address |
| bus_wdata | input | 32 | Bus write data, right-justified |
| bus_rdata | output | 32 | Registered bus read data |
| dbg_req | input | 1 | Maintenance access strobe |
| dbg_we | input | 1 | Maintenance write (1) or read (0) |
| dbg_addr | input | 32 | Byte offset into the memory |
| dbg_wdata | input | 32 | Maintenance write word |
| dbg_rdata | output | 32 | Registered maintenance read word |
| dbg_err_align | output | 1 | One-cycle pulse: misaligned maintenance address |
| dbg_err_range | output | 1 | One-cycle pulse: maintenance address past the end |

## Verification
The hardest state to reach is a same-cycle write from both ports to one word. The bus merge then has to use the stale word while the maintenance write lands in the same clock. The bench drives both strobes in one cycle, with a byte write on the bus and a full word on the maintenance side, and reads the word back through the bus. A second trap is an out-of-range bus offset whose low index bits alias word zero. The bench seeds word zero first and reads it back after the rejected write.

// File: rtl/nvls_pkg.sv
// Shared access-size encoding for the big-endian word store.
package nvls_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10
    } acc_size_e;
endpackage

// File: rtl/nvls_lane_merge.sv
// Builds the word to store for a bus write. Narrow data is replicated
// across lanes and a per-lane enable picks which lanes take it.
// Assumes lane holds the low two offset bits; big-endian lane order.
module nvls_lane_merge
    import nvls_pkg::*;
(
    input  logic [31:0] old_word,
    input  logic [31:0] wdata,
    input  logic [1:0]  size,
    input  logic [1:0]  lane,
    output logic [31:0] new_word,
    output logic        size_ok
);
    logic [3:0]  lane_en;
    logic [31:0] src;

    // Decode lane enables and replicate the source for the access size.
    always_comb begin
        size_ok = 1'b1;
        case (size)
            SZ_BYTE: begin
                lane_en = 4'b1000 >> lane;
                src     = {4{wdata[7:0]}};
            end
            SZ_HALF: begin
                lane_en = lane[1] ? 4'b0011 : 4'b1100;
                src     = {2{wdata[15:0]}};
            end
            SZ_WORD: begin
                lane_en = 4'b1111;
                src     = wdata;
            end
            default: begin
                lane_en = 4'b0000;
                src     = wdata;
                size_ok = 1'b0;
            end
        endcase
    end

    // Per-lane select between the stored byte and the new byte.
    for (genvar k = 0; k < 4; k++) begin : g_lane
        assign new_word[8*k +: 8] = lane_en[k] ? src[8*k +: 8] : old_word[8*k +: 8];
    end
endmodule

// File: rtl/nvls_lane_extract.sv
// Pulls the addressed byte, half or word out of a stored word and
// right-justifies it with zero extension. An illegal size yields zero.
module nvls_lane_extract
    import nvls_pkg::*;
(
    input  logic [31:0] word,
    input  logic [1:0]  size,
    input  logic [1:0]  lane,
    output logic [31:0] rdata
);
    logic [4:0] shamt;

    // Big-endian shift: lane 0 is the most significant byte.
    assign shamt = {~lane, 3'b000};

    // Select and zero-extend the addressed field.
    always_comb begin
        case (size)
            SZ_BYTE: rdata = (word >> shamt) & 32'h0000_00FF;
            SZ_HALF: rdata = lane[1] ? {16'h0, word[15:0]} : {16'h0, word[31:16]};
            SZ_WORD: rdata = word;
            default: rdata = 32'h0;
        endcase
    end
endmodule

// File: rtl/nvls_dbg_gate.sv
// Screens maintenance-port addresses. Misalignment is reported first.
// A range fault is reported only for an aligned address.
module nvls_dbg_gate #(
    parameter int DEPTH = 512
) (
    input  logic [31:0]              addr,
    output logic                     ok,
    output logic                     bad_align,
    output logic                     bad_range,
    output logic [$clog2(DEPTH)-1:0] idx
);
    localparam int          IDX_W = $clog2(DEPTH);
    localparam logic [31:0] LIMIT = 32'(DEPTH * 4);

    // Classify the address and derive the word index.
    always_comb begin
        bad_align = (addr[1:0] != 2'b00);
        bad_range = !bad_align && (addr >= LIMIT);
        ok        = !bad_align && !bad_range;
        idx       = addr[IDX_W+1:2];
    end
endmodule

// File: rtl/nvram_lane_store.sv
// Word-organised memory with big-endian byte/half/word bus access and
// an aligned-word maintenance port. Both ports have one-cycle
// registered reads of the pre-write contents. The bus write is applied
// after the maintenance write, so the bus result is kept on a clash.
module nvram_lane_store
    import nvls_pkg::*;
#(
    parameter int          DEPTH     = 512,
    parameter logic [31:0] BASE_ADDR = 32'h0004_3000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_req,
    input  logic        bus_we,
    input  logic [1:0]  bus_size,
    input  logic [31:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        dbg_req,
    input  logic        dbg_we,
    input  logic [31:0] dbg_addr,
    input  logic [31:0] dbg_wdata,
    output logic [31:0] dbg_rdata,
    output logic        dbg_err_align,
    output logic        dbg_err_range
);
    localparam int          IDX_W = $clog2(DEPTH);
    localparam logic [31:0] LIMIT = 32'(DEPTH * 4);

    logic [31:0]      mem [DEPTH];
    logic [31:0]      bus_off;
    logic             bus_hit;
    logic [IDX_W-1:0] bus_idx;
    logic [31:0]      old_word;
    logic [31:0]      merged;
    logic [31:0]      extracted;
    logic             size_ok;
    logic             bus_wr;
    logic             dbg_ok;
    logic             dbg_bad_align;
    logic             dbg_bad_range;
    logic [IDX_W-1:0] dbg_idx;
    logic             dbg_wr;

    // Translate the bus address into an in-window word index.
    always_comb begin
        bus_off  = bus_addr - BASE_ADDR;
        bus_hit  = (bus_off < LIMIT);
        bus_idx  = bus_off[IDX_W+1:2];
        old_word = mem[bus_idx];
    end

    nvls_lane_merge u_merge (
        .old_word (old_word),
        .wdata    (bus_wdata),
        .size     (bus_size),
        .lane     (bus_off[1:0]),
        .new_word (merged),
        .size_ok  (size_ok)
    );

    nvls_lane_extract u_extract (
        .word  (old_word),
        .size  (bus_size),
        .lane  (bus_off[1:0]),
        .rdata (extracted)
    );

    nvls_dbg_gate #(.DEPTH(DEPTH)) u_gate (
        .addr      (dbg_addr),
        .ok        (dbg_ok),
        .bad_align (dbg_bad_align),
        .bad_range (dbg_bad_range),
        .idx       (dbg_idx)
    );

    // Qualify writes from each port.
    assign bus_wr = bus_req && bus_we && bus_hit && size_ok;
    assign dbg_wr = dbg_req && dbg_we && dbg_ok;

    // Storage: clear on reset, maintenance write first, bus write last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 32'h0;
        end else begin
            if (dbg_wr) mem[dbg_idx] <= dbg_wdata;
            if (bus_wr) mem[bus_idx] <= merged;
        end
    end

    // Bus read register: loads on every bus read, zero when out of window.
    always_ff @(posedge clk) begin
        if (!rst_n)                 bus_rdata <= 32'h0;
        else if (bus_req && !bus_we) bus_rdata <= bus_hit ? extracted : 32'h0;
    end

    // Maintenance read register and one-cycle error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbg_rdata     <= 32'h0;
            dbg_err_align <= 1'b0;
            dbg_err_range <= 1'b0;
        end else begin
            dbg_err_align <= dbg_req && dbg_bad_align;
            dbg_err_range <= dbg_req && dbg_bad_range;
            if (dbg_req && !dbg_we) dbg_rdata <= dbg_ok ? mem[dbg_idx] : 32'h0;
            else if (dbg_req)       dbg_rdata <= 32'h0;
        end
    end

    AST_BADSIZE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_we && bus_size == 2'b11 |=> bus_rdata == 32'h0); // R6

    AST_OUT_OF_WINDOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_we && ((bus_addr - BASE_ADDR) >= LIMIT) |=> bus_rdata == 32'h0); // R7

    AST_MISALIGN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req && dbg_addr[1:0] != 2'b00 |=> dbg_err_align && dbg_rdata == 32'h0); // R8

    AST_PAST_END_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req && dbg_addr[1:0] == 2'b00 && dbg_addr >= LIMIT |=> dbg_err_range); // R9

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({dbg_err_align, dbg_err_range}) <= 1); // R9

    AST_NO_REQ_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_req |=> !dbg_err_align && !dbg_err_range); // R8
endmodule

// File: tb/sim_nvram_lane_store.sv
`timescale 1ns/1ps
module sim_nvram_lane_store;
    localparam int          DEPTH = 512;
    localparam logic [31:0] BASE  = 32'h0004_3000;
    localparam logic [31:0] LIM   = 32'(DEPTH * 4);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [1:0]  bus_size = 2'b10;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dbg_req = 1'b0, dbg_we = 1'b0;
    logic [31:0] dbg_addr = '0, dbg_wdata = '0;
    logic [31:0] dbg_rdata;
    logic        dbg_err_align, dbg_err_range;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    nvram_lane_store #(.DEPTH(DEPTH), .BASE_ADDR(BASE)) u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dbg_req(dbg_req), .dbg_we(dbg_we), .dbg_addr(dbg_addr),
        .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
        .dbg_err_align(dbg_err_align), .dbg_err_range(dbg_err_range)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    // One bus access; returns with read data registered.
    task automatic bus_op(input logic we, input logic [1:0] sz,
                          input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_size = sz; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic dbg_op(input logic we, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        dbg_req = 1'b1; dbg_we = we; dbg_addr = a; dbg_wdata = d;
        @(negedge clk);
        dbg_req = 1'b0; dbg_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 bus_rdata after reset", bus_rdata, 32'h0);
        chk("R1 dbg_rdata after reset", dbg_rdata, 32'h0);
        bus_op(1'b1, 2'b10, BASE + 32'h40, 32'h9999_8888);
        do_reset();
        bus_op(1'b0, 2'b10, BASE + 32'h40, 32'h0);
        chk("R1 word cleared by reset", bus_rdata, 32'h0);
        bus_op(1'b0, 2'b10, BASE + LIM - 4, 32'h0);
        chk("R1 last word zero", bus_rdata, 32'h0);
    endtask

    task automatic t_word();
        bus_op(1'b1, 2'b10, BASE + 32'h8, 32'h1122_3344);
        bus_op(1'b0, 2'b10, BASE + 32'h8, 32'h0);
        chk("R2 word readback", bus_rdata, 32'h1122_3344);
        bus_op(1'b0, 2'b10, BASE + 32'hC, 32'h0);
        chk("R2 neighbour word untouched", bus_rdata, 32'h0);
    endtask

    task automatic t_byte_read();
        bus_op(1'b1, 2'b10, BASE + 32'h10, 32'hA1B2_C3D4);
        bus_op(1'b0, 2'b00, BASE + 32'h10, 32'h0); chk("R3 byte lane 0", bus_rdata, 32'hA1);
        bus_op(1'b0, 2'b00, BASE + 32'h11, 32'h0); chk("R3 byte lane 1", bus_rdata, 32'hB2);
        bus_op(1'b0, 2'b00, BASE + 32'h12, 32'h0); chk("R3 byte lane 2", bus_rdata, 32'hC3);
        bus_op(1'b0, 2'b00, BASE + 32'h13, 32'h0); chk("R3 byte lane 3", bus_rdata, 32'hD4);
    endtask

    task automatic t_byte_write();
        bus_op(1'b1, 2'b00, BASE + 32'h12, 32'h0000_005E);
        bus_op(1'b0, 2'b10, BASE + 32'h10, 32'h0);
        chk("R4 byte write lane 2", bus_rdata, 32'hA1B2_5ED4);
        bus_op(1'b1, 2'b00, BASE + 32'h10, 32'hFFFF_FF77);
        bus_op(1'b0, 2'b10, BASE + 32'h10, 32'h0);
        chk("R4 byte write lane 0 uses low byte", bus_rdata, 32'h77B2_5ED4);
    endtask

    task automatic t_half();
        bus_op(1'b0, 2'b01, BASE + 32'h10, 32'h0); chk("R5 upper half", bus_rdata, 32'h77B2);
        bus_op(1'b0, 2'b01, BASE + 32'h12, 32'h0); chk("R5 lower half", bus_rdata, 32'h5ED4);
        bus_op(1'b0, 2'b01, BASE + 32'h13, 32'h0); chk("R5 bit0 ignored read", bus_rdata, 32'h5ED4);
        bus_op(1'b1, 2'b01, BASE + 32'h12, 32'hFFFF_CAFE);
        bus_op(1'b0, 2'b10, BASE + 32'h10, 32'h0); chk("R5 lower half write", bus_rdata, 32'h77B2_CAFE);
        bus_op(1'b1, 2'b01, BASE + 32'h11, 32'h0000_0102);
        bus_op(1'b0, 2'b10, BASE + 32'h10, 32'h0); chk("R5 upper half write bit0 ignored", bus_rdata, 32'h0102_CAFE);
    endtask

    task automatic t_badsize();
        bus_op(1'b1, 2'b11, BASE + 32'h10, 32'hFFFF_FFFF);
        bus_op(1'b0, 2'b10, BASE + 32'h10, 32'h0);
        chk("R6 illegal size writes nothing", bus_rdata, 32'h0102_CAFE);
        bus_op(1'b0, 2'b11, BASE + 32'h10, 32'h0);
        chk("R6 illegal size reads zero", bus_rdata, 32'h0);
    endtask

    task automatic t_oor();
        bus_op(1'b1, 2'b10, BASE, 32'h1357_2468);
        bus_op(1'b1, 2'b10, BASE + LIM, 32'hBAD0_BAD0);
        bus_op(1'b0, 2'b10, BASE, 32'h0);
        chk("R7 alias of word 0 untouched", bus_rdata, 32'h1357_2468);
        bus_op(1'b0, 2'b10, BASE + LIM, 32'h0);
        chk("R7 past end reads zero", bus_rdata, 32'h0);
        bus_op(1'b0, 2'b10, BASE, 32'h0);
        bus_op(1'b0, 2'b10, BASE - 4, 32'h0);
        chk("R7 below base reads zero", bus_rdata, 32'h0);
        bus_op(1'b1, 2'b10, BASE + LIM - 4, 32'h5A5A_A5A5);
        bus_op(1'b0, 2'b10, BASE + LIM - 4, 32'h0);
        chk("R7 last word in window usable", bus_rdata, 32'h5A5A_A5A5);
    endtask

    task automatic t_dbg_align();
        dbg_op(1'b1, 32'h12, 32'hFFFF_FFFF);
        chk("R8 align flag", {31'h0, dbg_err_align}, 32'h1);
        chk("R8 no range flag", {31'h0, dbg_err_range}, 32'h0);
        chk("R8 rdata zero", dbg_rdata, 32'h0);
        @(negedge clk);
        chk("R8 flag is one cycle", {31'h0, dbg_err_align}, 32'h0);
        bus_op(1'b0, 2'b10, BASE + 32'h10, 32'h0);
        chk("R8 rejected write left word", bus_rdata, 32'h0102_CAFE);
    endtask

    task automatic t_dbg_range();
        dbg_op(1'b0, 32'h10, 32'h0);
        chk("R10 debug read word", dbg_rdata, 32'h0102_CAFE);
        dbg_op(1'b0, LIM, 32'h0);
        chk("R9 range flag", {31'h0, dbg_err_range}, 32'h1);
        chk("R9 no align flag", {31'h0, dbg_err_align}, 32'h0);
        chk("R9 rdata zero", dbg_rdata, 32'h0);
        dbg_op(1'b1, LIM, 32'hEEEE_EEEE);
        bus_op(1'b0, 2'b10, BASE, 32'h0);
        chk("R9 rejected write left word 0", bus_rdata, 32'h1357_2468);
        dbg_op(1'b0, LIM - 4, 32'h0);
        chk("R9 last word accepted no flag", {30'h0, dbg_err_align, dbg_err_range}, 32'h0);
        chk("R9 last word data", dbg_rdata, 32'h5A5A_A5A5);
    endtask

    task automatic t_dbg_rw();
        dbg_op(1'b1, 32'h20, 32'hDEAD_BEEF);
        bus_op(1'b0, 2'b00, BASE + 32'h20, 32'h0);
        chk("R10 bus sees debug write", bus_rdata, 32'hDE);
        dbg_op(1'b0, 32'h20, 32'h0);
        chk("R10 debug readback", dbg_rdata, 32'hDEAD_BEEF);
    endtask

    task automatic t_collide();
        @(negedge clk);
        dbg_req = 1'b1; dbg_we = 1'b1; dbg_addr = 32'h30; dbg_wdata = 32'h1111_1111;
        bus_req = 1'b1; bus_we = 1'b1; bus_size = 2'b00; bus_addr = BASE + 32'h33; bus_wdata = 32'hAA;
        @(negedge clk);
        dbg_req = 1'b0; dbg_we = 1'b0; bus_req = 1'b0; bus_we = 1'b0;
        bus_op(1'b0, 2'b10, BASE + 32'h30, 32'h0);
        chk("R11 bus wins merged on old word", bus_rdata, 32'h0000_00AA);
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_word();
        t_byte_read();
        t_byte_write();
        t_half();
        t_badsize();
        t_oor();
        t_dbg_align();
        t_dbg_range();
        t_dbg_rw();
        t_collide();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule